// File: doc/BRIEF.md
# Half-Bridge PWM Generator with Dead Band

This block drives the two switches of a transistor half bridge from a single free-running counter. One output (A) is the high-side drive, active while the counter is below the duty value. The other output (B) is the complementary low-side drive. A programmable dead band of 0 to 15 clock ticks is inserted by delaying the rising edge of each output. Because of this, the two drives are never active on the same tick, and a gap is kept both inside the period and across the counter wrap.

Duty and dead band are plain parallel inputs from any controller. They are captured into shadow registers once per period, on the last tick before the counter returns to zero. A new setting therefore always starts cleanly at the top of a period. Both outputs come from flip-flops. A synchronous, active-high reset restarts the period.

Top module: `hb_pwm_deadband`

## Requirements
- R1: An 8-bit counter advances by one on every clock edge outside reset and wraps from 255 to 0, so the period is always 256 ticks.
- R2: Output A, registered, is 1 on the tick after counter value c exactly when c < duty and c >= gap (both unsigned).
- R3: Output B, registered, is 1 on the tick after counter value c exactly when c >= duty + gap, with the sum formed 9 bits wide; when duty + gap exceeds 255, B stays 0 for the whole period.
- R4: A and B are never 1 on the same tick.
- R5: With duty 0, A never goes high and B is high for counter values from gap up to 255.
- R6: When duty is less than or equal to gap, A stays 0 for the whole period.
- R7: duty_in and gap_in are captured only on the edge where the counter leaves 255. A change during a period has no effect until the next period begins.
- R8: While rst is 1 at a clock edge, the counter is set to 0, both outputs are driven to 0 and the current duty_in and gap_in are captured for the first period.
- R9: With duty 255 and gap 0, A is high for 255 ticks of each period and B for one tick (counter value 255).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| duty_in | input | 8 | Duty value, unsigned; 0 is 0 %, 255 is full scale |
| gap_in | input | 4 | Dead band in clock ticks, 0 to 15 |
| out_a | output | 1 | High-side drive, registered |
| out_b | output | 1 | Low-side drive, registered |

## Verification
The bench walks twelve duty and dead-band settings and compares every tick of a full period against a counter-based reference. The settings are chosen to separate the cases that matter:
- a typical mid-range point;
- duty 0 and duty 255;
- duty equal to or below the dead band, which keeps A silent;
- sums of exactly 255, 256 and above, which exposes a sum truncated to 8 bits.

Each next setting is applied halfway through the current period, so a design that captures its inputs at the wrong time shows up as a per-tick mismatch. The per-period high counts confirm the 256-tick period. A reset in the middle of a run, with new settings applied during reset, confirms the restart and the capture on reset.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;

    localparam int CNT_W = 8;
    localparam int GAP_W = 4;
    localparam int SUM_W = CNT_W + 1;

    typedef logic [CNT_W-1:0] count_t;

    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic [GAP_W-1:0] gap;
    } setting_t;

    typedef struct packed {
        logic a;
        logic b;
    } drive_t;

    // Point where B may rise; one bit wider than the counter.
    function automatic logic [SUM_W-1:0] b_start(input setting_t s);
        return {1'b0, s.duty} + SUM_W'(s.gap);
    endfunction

endpackage

// File: rtl/hb_pwm_counter.sv
module hb_pwm_counter
    import hb_pwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output count_t count,
    output logic   last
);

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    assign last = (count == {CNT_W{1'b1}});

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == CNT_W'($past(count) + 1'b1));

endmodule

// File: rtl/hb_pwm_shadow.sv
module hb_pwm_shadow
    import hb_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     last,
    input  setting_t live,
    output setting_t held
);

    always_ff @(posedge clk) begin
        if (rst || last) held <= live;
    end

    // R7
    shadow_hold_chk: assert property (@(posedge clk)
        (!rst && !last) |=> $stable(held));

endmodule

// File: rtl/hb_pwm_compare.sv
module hb_pwm_compare
    import hb_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  count_t   count,
    input  setting_t cfg,
    output drive_t   drv
);

    logic [SUM_W-1:0] b_edge;
    logic             a_next;
    logic             b_next;

    always_comb begin
        b_edge = b_start(cfg);
        a_next = (count < cfg.duty) && (count >= CNT_W'(cfg.gap));
        b_next = ({1'b0, count} >= b_edge);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv <= '0;
        end else begin
            drv.a <= a_next;
            drv.b <= b_next;
        end
    end

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(drv.a && drv.b));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!drv.a && !drv.b));

    // R6
    a_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.duty <= CNT_W'(cfg.gap) && $stable(cfg)) |=> !drv.a);

endmodule

// File: rtl/hb_pwm_deadband.sv
module hb_pwm_deadband
    import hb_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [GAP_W-1:0] gap_in,
    output logic             out_a,
    output logic             out_b
);

    count_t   count;
    logic     last;
    setting_t live;
    setting_t held;
    drive_t   drv;

    assign live.duty = duty_in;
    assign live.gap  = gap_in;

    hb_pwm_counter u_counter (
        .clk   (clk),
        .rst   (rst),
        .count (count),
        .last  (last)
    );

    hb_pwm_shadow u_shadow (
        .clk  (clk),
        .rst  (rst),
        .last (last),
        .live (live),
        .held (held)
    );

    hb_pwm_compare u_compare (
        .clk   (clk),
        .rst   (rst),
        .count (count),
        .cfg   (held),
        .drv   (drv)
    );

    assign out_a = drv.a;
    assign out_b = drv.b;

endmodule

// File: tb/hb_pwm_deadband_tb_top.sv
`timescale 1ns/1ps
module hb_pwm_deadband_tb_top;

    localparam int NV = 12;
    // {duty[8], gap[4], A high ticks[9], B high ticks[9]}
    localparam logic [29:0] VEC [NV] = '{
        {8'd200, 4'd12, 9'd188, 9'd44 },
        {8'd0,   4'd0,  9'd0,   9'd256},
        {8'd255, 4'd0,  9'd255, 9'd1  },
        {8'd0,   4'd5,  9'd0,   9'd251},
        {8'd128, 4'd15, 9'd113, 9'd113},
        {8'd10,  4'd10, 9'd0,   9'd236},
        {8'd5,   4'd12, 9'd0,   9'd239},
        {8'd250, 4'd10, 9'd240, 9'd0  },
        {8'd241, 4'd15, 9'd226, 9'd0  },
        {8'd240, 4'd15, 9'd225, 9'd1  },
        {8'd100, 4'd0,  9'd100, 9'd156},
        {8'd255, 4'd15, 9'd240, 9'd0  }
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] duty_in = '0;
    logic [3:0] gap_in = '0;
    logic       out_a;
    logic       out_b;

    int errors = 0;
    int checks = 0;
    int late_bad = 0;
    int a_seen [NV];
    int b_seen [NV];
    bit done = 1'b0;

    always #2 clk = ~clk;

    hb_pwm_deadband dut_i (
        .clk     (clk),
        .rst     (rst),
        .duty_in (duty_in),
        .gap_in  (gap_in),
        .out_a   (out_a),
        .out_b   (out_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts at a negedge whose next edge sees counter value 0.
    task automatic run_period(input int d, input int g, input bit chg,
                              input int nd, input int ng,
                              output int ca, output int cb);
        ca = 0;
        cb = 0;
        for (int n = 0; n < 256; n++) begin
            bit ea;
            bit eb;
            @(posedge clk);
            @(negedge clk);
            ea = (n < d) && (n >= g);
            eb = (n >= d + g);
            chk(out_a == ea, "R2", out_a, ea);
            chk(out_b == eb, "R3", out_b, eb);
            chk(!(out_a && out_b), "R4", out_a + out_b, 1);
            if (n > 128 && (out_a != ea || out_b != eb)) late_bad++;
            ca += out_a;
            cb += out_b;
            if (n == 128 && chg) begin
                duty_in = 8'(nd);
                gap_in  = 4'(ng);
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ca;
        int cb;
        duty_in = VEC[0][29:22];
        gap_in  = VEC[0][21:18];
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_a && !out_b, "R8", out_a + out_b, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            int nx;
            nx = (i + 1 < NV) ? i + 1 : i;
            run_period(VEC[i][29:22], VEC[i][21:18], i + 1 < NV,
                       VEC[nx][29:22], VEC[nx][21:18], ca, cb);
            a_seen[i] = ca;
            b_seen[i] = cb;
            // R1: fixed 256-tick period gives these totals
            chk(ca == int'(VEC[i][17:9]), "R1", ca, VEC[i][17:9]);
            chk(cb == int'(VEC[i][8:0]),  "R1", cb, VEC[i][8:0]);
        end

        // R7: changes made mid-period never showed in the second half
        chk(late_bad == 0, "R7", late_bad, 0);
        // R5: duty 0
        chk(a_seen[1] == 0 && b_seen[1] == 256, "R5", b_seen[1], 256);
        chk(a_seen[3] == 0 && b_seen[3] == 251, "R5", b_seen[3], 251);
        // R6: duty at or below gap
        chk(a_seen[5] == 0, "R6", a_seen[5], 0);
        chk(a_seen[6] == 0, "R6", a_seen[6], 0);
        // R3: sum of 256 and above keeps B low
        chk(b_seen[7] == 0 && b_seen[8] == 0, "R3", b_seen[7] + b_seen[8], 0);
        // R9: full-scale duty
        chk(a_seen[2] == 255 && b_seen[2] == 1, "R9", a_seen[2], 255);

        // R8: reset mid-run, new settings captured during reset
        @(negedge clk);
        rst = 1'b1;
        duty_in = 8'd50;
        gap_in  = 4'd3;
        @(posedge clk);
        @(negedge clk);
        chk(!out_a && !out_b, "R8", out_a + out_b, 0);
        rst = 1'b0;
        run_period(50, 3, 1'b0, 0, 0, ca, cb);
        chk(ca == 47, "R8", ca, 47);
        chk(cb == 203, "R8", cb, 203);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule